// File: doc/BRIEF.md
# SDRAM Four-Bank Command Legality Tracker

This block watches the command pins of a four-bank synchronous DRAM and keeps a live model of every bank: idle, opening a row, row open, bursting a read, bursting a write, running a burst that closes itself, recovering after write data, or closing the row. On every clock edge where commands are decoded, it looks up the target bank (or all banks), checks the command against that bank's state and against the tRCD, tRP, tRRD and tWR windows, and reports a verdict with a reason code. Only accepted commands move bank state, so the model stays aligned with what the memory itself would do.

It is meant to sit beside a memory controller, either as a live monitor or as a gate whose verdict stops an illegal command before it reaches the pins. All timing windows are counted in clock cycles and set by parameters. Data movement and refresh scheduling are handled elsewhere.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset every bank reads state code 0 (idle) and no verdict is flagged (cmd_seen and cmd_legal low, cmd_why 0).
- R2: bank_sel picks bank 0 to 3, and bank b's state sits in bank_state bits [3b+2:3b]. A precharge with a10 low closes only the selected bank; with a10 high it closes every bank that has a row open, whatever bank_sel says.
- R3: A read or write to a bank that is idle or closing is rejected with reason 1; an activate to a bank that is not idle is rejected with reason 2.
- R4: With cs_n high the command pins are ignored: no verdict is flagged and no bank state moves.
- R5: Refresh and mode set are accepted only when all four banks are idle; otherwise they are rejected with reason 3.
- R6: A read or write reaching a bank fewer than T_RCD cycles after its activate is rejected with reason 4; at exactly T_RCD cycles it is accepted.
- R7: Two accepted activates are at least T_RRD cycles apart; an activate sooner than that is rejected with reason 6.
- R8: A write leaves the bank in state 4 (write) until its last data beat, then state 6 (write recovery) for T_WR cycles; a precharge to a bank in state 4 or 6 is rejected with reason 7. An accepted precharge puts the bank in state 7 and an activate to it is rejected until T_RP cycles have passed.
- R9: A read or write with a10 high puts the bank in state 5; it stays there for the burst (plus T_WR after a write), then state 7 for T_RP cycles, then idle. Read, write or precharge to a bank in state 5 is rejected with reason 5.
- R10: When cke was low at the previous clock edge, the command at the current edge is not decoded: no verdict and no state change.
- R11: Commands are decoded from (ras_n, cas_n, we_n) as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 111 no-op. The verdict for a command sampled at an edge is presented right after that edge; a rejected command changes no bank state.
- R12: A read puts the bank in state 3 for BURST_LEN cycles, after which the bank returns to state 2 (row open); state 1 marks a bank opening a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin; low masks decoding at the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge on read/write, all-bank select on precharge |
| bank_state | output | 12 | Four 3-bit bank state codes, bank 0 in the low bits |
| cmd_seen | output | 1 | A non-no-op command was decoded at the last edge |
| cmd_legal | output | 1 | That command was legal |
| cmd_why | output | 3 | Reason code, 0 when legal |

## Verification
Verdict and bank state for a command sampled at edge N both appear just after edge N, so the bench drives each command on a falling edge and checks both on the next falling edge. Timing windows are probed by counting edges from the opening command: a command one edge before the window closes must be refused and the same command on the closing edge accepted. State codes for bursts and automatic closes are read at exact edge counts after the command (for example, idle again BURST_LEN + T_RP edges after a read with a10 high).

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int ST_W      = 3;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_OPENING = 3'd1,
        BK_OPEN    = 3'd2,
        BK_READ    = 3'd3,
        BK_WRITE   = 3'd4,
        BK_AUTOPRE = 3'd5,
        BK_WREC    = 3'd6,
        BK_CLOSING = 3'd7
    } bank_st_e;

    typedef enum logic [2:0] {
        OP_NOP, OP_BST, OP_RD, OP_WR, OP_ACT, OP_PRE, OP_REF, OP_MRS
    } op_e;

    typedef enum logic [2:0] {
        WHY_OK       = 3'd0,
        WHY_NOT_OPEN = 3'd1,
        WHY_BUSY     = 3'd2,
        WHY_NOT_IDLE = 3'd3,
        WHY_TRCD     = 3'd4,
        WHY_AUTOPRE  = 3'd5,
        WHY_TRRD     = 3'd6,
        WHY_TWR      = 3'd7
    } why_e;

    typedef struct packed {
        op_e               op;
        logic [BANK_W-1:0] bank;
        logic              a10;
    } cmd_t;

    function automatic op_e decode_op(input logic ras_n, input logic cas_n, input logic we_n);
        case ({ras_n, cas_n, we_n})
            3'b111:  return OP_NOP;
            3'b110:  return OP_BST;
            3'b101:  return OP_RD;
            3'b100:  return OP_WR;
            3'b011:  return OP_ACT;
            3'b010:  return OP_PRE;
            3'b001:  return OP_REF;
            default: return OP_MRS;
        endcase
    endfunction

    // State a bank moves to once its current timed phase runs out
    function automatic bank_st_e settle(input bank_st_e s);
        case (s)
            BK_OPENING: return BK_OPEN;
            BK_READ:    return BK_OPEN;
            BK_WRITE:   return BK_WREC;
            BK_WREC:    return BK_OPEN;
            BK_AUTOPRE: return BK_CLOSING;
            BK_CLOSING: return BK_IDLE;
            default:    return s;
        endcase
    endfunction

    function automatic logic row_open(input bank_st_e s);
        return (s == BK_OPEN) || (s == BK_READ) || (s == BK_WRITE) || (s == BK_WREC);
    endfunction

endpackage

// File: rtl/sgd_decode.sv
module sgd_decode
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              a10,
    output cmd_t              cmd,
    output logic              live
);
    logic cke_q;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end

    assign live     = cke_q;
    assign cmd.op   = cs_n ? OP_NOP : decode_op(ras_n, cas_n, we_n);
    assign cmd.bank = bank_sel;
    assign cmd.a10  = a10;
endmodule

// File: rtl/sgd_bank.sv
module sgd_bank
    import sgd_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_WR      = 1,
    parameter int CW        = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  op_e      op,
    input  logic     a10,
    input  logic     take,
    input  logic     mine,
    output bank_st_e st,
    output bank_st_e eff
);
    // A one-beat write goes straight to recovery
    localparam bank_st_e WR_ST  = (BURST_LEN > 1) ? BK_WRITE : BK_WREC;
    localparam int       WR_CNT = (BURST_LEN > 1) ? BURST_LEN - 2 : T_WR - 1;

    logic [CW-1:0] cnt, ncnt;
    bank_st_e      nxt;

    always_comb begin
        eff = (cnt == '0) ? settle(st) : st;
        nxt = eff;
        if (cnt != '0)                                   ncnt = cnt - 1'b1;
        else if (eff == BK_WREC    && st != BK_WREC)     ncnt = CW'(T_WR - 1);
        else if (eff == BK_CLOSING && st != BK_CLOSING)  ncnt = CW'(T_RP - 1);
        else                                             ncnt = '0;

        if (take) begin
            case (op)
                OP_ACT: if (mine) begin
                    nxt = BK_OPENING; ncnt = CW'(T_RCD - 1);
                end
                OP_RD: if (mine) begin
                    nxt  = a10 ? BK_AUTOPRE : BK_READ;
                    ncnt = CW'(BURST_LEN - 1);
                end
                OP_WR: if (mine) begin
                    if (a10) begin
                        nxt = BK_AUTOPRE; ncnt = CW'(BURST_LEN - 2 + T_WR);
                    end else begin
                        nxt = WR_ST; ncnt = CW'(WR_CNT);
                    end
                end
                OP_PRE: if ((mine || a10) && row_open(eff)) begin
                    nxt = BK_CLOSING; ncnt = CW'(T_RP - 1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= ncnt;
        end
    end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sgd_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cke,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BANK_W-1:0]         bank_sel,
    input  logic                      a10,
    output logic [NUM_BANKS*ST_W-1:0] bank_state,
    output logic                      cmd_seen,
    output logic                      cmd_legal,
    output logic [2:0]                cmd_why
);
    localparam int CW = $clog2(BURST_LEN + T_WR + T_RCD + T_RP + T_RRD + 1);

    cmd_t          cmd;
    logic          live, take, act_take, seen_d;
    logic          all_idle, any_wr, any_ap;
    why_e          why;
    bank_st_e      tgt;
    bank_st_e      st  [NUM_BANKS];
    bank_st_e      eff [NUM_BANKS];
    logic [CW-1:0] rrd_cnt;

    sgd_decode u_dec (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .a10(a10),
        .cmd(cmd), .live(live)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sgd_bank #(
            .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .CW(CW)
        ) u_bank (
            .clk(clk), .rst(rst), .op(cmd.op), .a10(cmd.a10), .take(take),
            .mine(cmd.bank == BANK_W'(b)), .st(st[b]), .eff(eff[b])
        );
        assign bank_state[b*ST_W +: ST_W] = st[b];
    end

    always_comb begin
        all_idle = 1'b1;
        any_wr   = 1'b0;
        any_ap   = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (eff[b] != BK_IDLE) all_idle = 1'b0;
            if (eff[b] == BK_WRITE || eff[b] == BK_WREC) any_wr = 1'b1;
            if (eff[b] == BK_AUTOPRE) any_ap = 1'b1;
        end
        tgt = eff[cmd.bank];
        why = WHY_OK;
        case (cmd.op)
            OP_RD, OP_WR: begin
                if (tgt == BK_AUTOPRE)      why = WHY_AUTOPRE;
                else if (tgt == BK_OPENING) why = WHY_TRCD;
                else if (!row_open(tgt))    why = WHY_NOT_OPEN;
            end
            OP_ACT: begin
                if (tgt != BK_IDLE)     why = WHY_BUSY;
                else if (rrd_cnt != '0) why = WHY_TRRD;
            end
            OP_PRE: begin
                if (cmd.a10) begin
                    if (any_wr)      why = WHY_TWR;
                    else if (any_ap) why = WHY_AUTOPRE;
                end else begin
                    if (tgt == BK_WRITE || tgt == BK_WREC) why = WHY_TWR;
                    else if (tgt == BK_AUTOPRE)            why = WHY_AUTOPRE;
                end
            end
            OP_REF, OP_MRS: if (!all_idle) why = WHY_NOT_IDLE;
            default: ;
        endcase
        seen_d   = live && (cmd.op != OP_NOP);
        take     = live && (why == WHY_OK);
        act_take = take && (cmd.op == OP_ACT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rrd_cnt   <= '0;
            cmd_seen  <= 1'b0;
            cmd_legal <= 1'b0;
            cmd_why   <= WHY_OK;
        end else begin
            if (act_take)           rrd_cnt <= CW'(T_RRD - 1);
            else if (rrd_cnt != '0) rrd_cnt <= rrd_cnt - 1'b1;
            cmd_seen  <= seen_d;
            cmd_legal <= seen_d && (why == WHY_OK);
            cmd_why   <= seen_d ? why : WHY_OK;
        end
    end
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
    import sgd_pkg::*;
#(
    parameter int T_RRD = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cke,
    input logic                      cs_n,
    input logic [NUM_BANKS*ST_W-1:0] bank_state,
    input logic                      cmd_seen,
    input logic                      cmd_legal,
    input logic [2:0]                cmd_why,
    input logic                      act_take
);
    localparam int GW = $clog2(T_RRD + 1) + 1;
    logic [GW-1:0] since_act;

    always_ff @(posedge clk) begin
        if (rst)                         since_act <= GW'(T_RRD);
        else if (act_take)               since_act <= GW'(1);
        else if (since_act < GW'(T_RRD)) since_act <= since_act + 1'b1;
    end

    AST_LEGAL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        cmd_legal |-> (cmd_seen && cmd_why == 3'd0)); // R11
    AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (cmd_seen && !cmd_legal) |-> (cmd_why != 3'd0)); // R11
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> !cmd_seen); // R4
    AST_CKE_MASK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(cke, 2)) |-> !cmd_seen); // R10
    AST_RRD_GAP: assert property (@(posedge clk) disable iff (rst)
        act_take |-> (since_act >= GW'(T_RRD))); // R7

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
        AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
            (bank_state[b*ST_W +: ST_W] == BK_IDLE) |=>
            (bank_state[b*ST_W +: ST_W] inside {BK_IDLE, BK_OPENING})); // R3
        AST_CLOSE_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
            (bank_state[b*ST_W +: ST_W] == BK_CLOSING) |=>
            (bank_state[b*ST_W +: ST_W] inside {BK_CLOSING, BK_IDLE})); // R8
        AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
            (bank_state[b*ST_W +: ST_W] == BK_AUTOPRE) |=>
            (bank_state[b*ST_W +: ST_W] inside {BK_AUTOPRE, BK_CLOSING})); // R9
    end
endmodule

bind sdram_cmd_guard sgd_checker #(.T_RRD(T_RRD)) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .bank_state(bank_state),
    .cmd_seen(cmd_seen), .cmd_legal(cmd_legal), .cmd_why(cmd_why),
    .act_take(act_take)
);

// File: tb/sdram_cmd_guard_test.sv
module sdram_cmd_guard_test;
    localparam logic [2:0] C_NOP = 3'b111, C_RD = 3'b101, C_WR = 3'b100,
                           C_ACT = 3'b011, C_PRE = 3'b010, C_REF = 3'b001,
                           C_MRS = 3'b000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bank_sel = 2'd0;
    logic        a10 = 1'b0;
    logic [11:0] bank_state;
    logic        cmd_seen, cmd_legal;
    logic [2:0]  cmd_why;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    sdram_cmd_guard uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .a10(a10),
        .bank_state(bank_state), .cmd_seen(cmd_seen), .cmd_legal(cmd_legal),
        .cmd_why(cmd_why)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bst(input int b);
        return int'(bank_state[3*b +: 3]);
    endfunction

    // verdict packed as seen*16 + legal*8 + why
    function automatic int verdict();
        return int'(cmd_seen) * 16 + int'(cmd_legal) * 8 + int'(cmd_why);
    endfunction

    task automatic issue(input logic ck, input logic csn, input logic [2:0] rcw,
                         input logic [1:0] b, input logic ap);
        cke = ck; cs_n = csn; {ras_n, cas_n, we_n} = rcw; bank_sel = b; a10 = ap;
        @(posedge clk); @(negedge clk);
        cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; bank_sel = 2'd0; a10 = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] rcw, input logic [1:0] b, input logic ap);
        issue(1'b1, 1'b0, rcw, b, ap);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(1'b1, 1'b1, C_NOP, 2'd0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 bank_state", int'(bank_state), 0);
        check("R1 verdict", verdict(), 0);
    endtask

    task automatic t_open_read();
        do_reset();
        cmd(C_RD, 2'd0, 1'b0);
        check("R3 read idle bank", verdict(), 16 + 1);
        check("R11 rejected keeps state", bst(0), 0);
        cmd(C_ACT, 2'd0, 1'b0);
        check("R11 activate verdict", verdict(), 24);
        check("R12 opening code", bst(0), 1);
        cmd(C_RD, 2'd0, 1'b0);
        check("R6 read inside tRCD", verdict(), 16 + 4);
        cmd(C_RD, 2'd0, 1'b0);
        check("R6 read at tRCD", verdict(), 24);
        check("R12 reading code", bst(0), 3);
        idle(3);
        check("R12 still bursting", bst(0), 3);
        idle(1);
        check("R12 burst done", bst(0), 2);
        cmd(C_ACT, 2'd0, 1'b0);
        check("R3 activate open bank", verdict(), 16 + 2);
    endtask

    task automatic t_rrd();
        do_reset();
        cmd(C_ACT, 2'd0, 1'b0);
        cmd(C_ACT, 2'd1, 1'b0);
        check("R7 activate inside tRRD", verdict(), 16 + 6);
        check("R11 rejected activate no state", bst(1), 0);
        cmd(C_ACT, 2'd1, 1'b0);
        check("R7 activate at tRRD", verdict(), 24);
        check("R2 bank fields", int'(bank_state), (1 << 3) | 2);
        cmd(C_ACT, 2'd3, 1'b0);
        check("R7 third activate early", verdict(), 16 + 6);
        cmd(C_ACT, 2'd3, 1'b0);
        check("R2 bank 3 field", bst(3), 1);
    endtask

    task automatic t_write_pre();
        do_reset();
        cmd(C_ACT, 2'd2, 1'b0);
        idle(1);
        cmd(C_WR, 2'd2, 1'b0);
        check("R8 write accepted", verdict(), 24);
        check("R8 writing code", bst(2), 4);
        idle(2);
        check("R8 still writing", bst(2), 4);
        cmd(C_PRE, 2'd2, 1'b0);
        check("R8 precharge inside tWR", verdict(), 16 + 7);
        check("R8 recovery code", bst(2), 6);
        cmd(C_PRE, 2'd2, 1'b0);
        check("R8 precharge after tWR", verdict(), 24);
        check("R8 closing code", bst(2), 7);
        cmd(C_ACT, 2'd2, 1'b0);
        check("R8 activate inside tRP", verdict(), 16 + 2);
        cmd(C_ACT, 2'd2, 1'b0);
        check("R8 activate after tRP", verdict(), 24);
    endtask

    task automatic t_autopre();
        do_reset();
        cmd(C_ACT, 2'd1, 1'b0);
        idle(1);
        cmd(C_RD, 2'd1, 1'b1);
        check("R9 read with close", verdict(), 24);
        check("R9 auto-close code", bst(1), 5);
        cmd(C_WR, 2'd1, 1'b0);
        check("R9 write during auto-close", verdict(), 16 + 5);
        cmd(C_PRE, 2'd1, 1'b0);
        check("R9 precharge during auto-close", verdict(), 16 + 5);
        idle(1);
        check("R9 burst still running", bst(1), 5);
        idle(1);
        check("R9 closing after burst", bst(1), 7);
        idle(2);
        check("R9 idle after tRP", bst(1), 0);
    endtask

    task automatic t_pre_all();
        do_reset();
        cmd(C_ACT, 2'd0, 1'b0);
        idle(1);
        cmd(C_ACT, 2'd3, 1'b0);
        idle(2);
        check("R2 both open", int'(bank_state), (2 << 9) | 2);
        cmd(C_PRE, 2'd3, 1'b0);
        check("R2 single precharge", int'(bank_state), (7 << 9) | 2);
        cmd(C_PRE, 2'd1, 1'b1);
        check("R2 all-bank precharge verdict", verdict(), 24);
        check("R2 all-bank precharge", int'(bank_state), (7 << 9) | 7);
    endtask

    task automatic t_all_idle();
        do_reset();
        cmd(C_MRS, 2'd0, 1'b0);
        check("R5 mode set all idle", verdict(), 24);
        cmd(C_ACT, 2'd0, 1'b0);
        cmd(C_REF, 2'd0, 1'b0);
        check("R5 refresh with open bank", verdict(), 16 + 3);
        cmd(C_MRS, 2'd0, 1'b0);
        check("R5 mode set with open bank", verdict(), 16 + 3);
    endtask

    task automatic t_deselect();
        do_reset();
        issue(1'b1, 1'b1, C_ACT, 2'd0, 1'b0);
        check("R4 deselected activate", verdict(), 0);
        check("R4 no state change", int'(bank_state), 0);
        issue(1'b1, 1'b1, C_RD, 2'd0, 1'b0);
        check("R4 deselected read", verdict(), 0);
    endtask

    task automatic t_cke();
        do_reset();
        issue(1'b0, 1'b1, C_NOP, 2'd0, 1'b0);
        cmd(C_ACT, 2'd0, 1'b0);
        check("R10 masked edge verdict", verdict(), 0);
        check("R10 masked edge state", bst(0), 0);
        cmd(C_ACT, 2'd0, 1'b0);
        check("R10 decoding resumes", verdict(), 24);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_open_read();
        t_rrd();
        t_write_pre();
        t_autopre();
        t_pre_all();
        t_all_idle();
        t_deselect();
        t_cke();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule